// File: doc/BRIEF.md
# Table-Indirect Execute Front-End

This unit sits between instruction fetch and decode. It watches a stream of 16-bit instructions for one particular compressed opcode, the "execute from table" form. When that opcode arrives, the unit collects a 10-bit table index from bits scattered through the instruction word. It then reads one 32-bit word from a table whose base comes from a user-level register. It hands that word to the decoder in place of the 16-bit instruction. The successor PC stays at the 16-bit instruction's PC plus 2.

If the table word is a JAL, the unit also produces a jump target. The target keeps the upper bits of the current PC and replaces the low 21 bits with the JAL's immediate, read as an unsigned value. A set flag bit in the table-base register selects a hardware-resident table, which this unit does not support. In that case the instruction is reported as illegal and no memory read is made. A bus error on the table read is reported as an instruction access fault.

Any other 16-bit instruction passes through unchanged, zero-extended, with no memory traffic. The unit accepts one instruction at a time through a valid/ready pair. It keeps its result on the output until the decoder accepts it.

Top module: `tblx_unit`

## Requirements
- R1: An input is recognised when `(in_insn & 16'hE083) == 16'h8000`. Any other input is presented as `{16'h0, in_insn}` with the illegal, fault and redirect flags low, and no memory request is made.
- R2: For a recognised input with `tbase[0]==0`, exactly one read is requested. Its address is `(tbase & ~3) + 4*idx`, where idx (MSB first) is in_insn bits 8, 12, 3, 9, 6, 5, 2, 11, 10, 4.
- R3: For a recognised input with `tbase[0]==1`, `out_illegal` is 1, `out_insn` is `{16'h0, in_insn}` and no memory request is made.
- R4: After a successful read, `out_insn` equals `mem_rdata`, and `out_next_pc` (also the JAL link value) equals `in_pc + 2` for every completed instruction.
- R5: When the fetched word has bits 6:0 equal to 7'b1101111, `out_redirect` is 1. `out_target` is then `{in_pc[31:21], w[31], w[19:12], w[20], w[30:21], 1'b0}`. For any other fetched word, `out_redirect` is 0.
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and drops in the cycle after the acknowledge.
- R7: An acknowledge with `mem_err` set gives `out_fault`=1, `out_insn`=0, and `out_redirect`=0 and `out_illegal`=0.
- R8: A result stays on the outputs, unchanged, while `out_valid` is high and `out_ready` is low. `in_ready` is high only when the unit holds no instruction.
- R9: After reset, `in_ready` is 1, and `out_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A 16-bit instruction is offered |
| in_ready | output | 1 | Unit can take an instruction |
| in_insn | input | 16 | 16-bit instruction |
| in_pc | input | XLEN | PC of that instruction |
| tbase | input | XLEN | Table-base register; bit 0 selects a hardware table |
| mem_req | output | 1 | Table read request |
| mem_addr | output | XLEN | Table read byte address, word aligned |
| mem_ack | input | 1 | Read completes this cycle |
| mem_err | input | 1 | Read completed with a bus error |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Decoder takes the result |
| out_insn | output | 32 | Instruction handed to the decoder |
| out_next_pc | output | XLEN | Sequential successor PC and link value |
| out_redirect | output | 1 | out_target overrides the jump target |
| out_target | output | XLEN | Region-absolute JAL target |
| out_illegal | output | 1 | Illegal-instruction exception |
| out_fault | output | 1 | Instruction access fault |

## Verification
A wrong index gather or wrong base masking appears on `mem_addr` in the cycle after the instruction is accepted. A lost or stale result register appears on `out_insn` or `out_target` in the first cycle `out_valid` is high. A state machine stuck in the fetch or output state shows up as `in_ready` staying low, or as a request missing when expected or issued when not expected. The bench sweeps all 1024 table indices with varied base, PC, acknowledge delay and backpressure. It also covers every single-bit miss of the opcode pattern, the hardware-table flag and bus errors. Each outcome is checked within a few cycles of the stimulus.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_OUT} tblx_state_e;
  localparam logic [15:0] XIT_MASK  = 16'hE083;
  localparam logic [15:0] XIT_MATCH = 16'h8000;
  localparam logic [6:0]  OPC_JAL   = 7'b1101111;
  localparam int IDX_W    = 10;
  localparam int REGION_W = 21;
endpackage

// File: rtl/tblx_decode.sv
module tblx_decode
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0]     insn,
  input  logic [XLEN-1:0] base,
  output logic            hit,
  output logic            hw_tab,
  output logic [XLEN-1:0] addr
);
  localparam int PadW = XLEN - IDX_W - 2;

  logic [IDX_W-1:0] idx;

  always_comb begin
    hit    = (insn & XIT_MASK) == XIT_MATCH;
    hw_tab = base[0];
    // scrambled index, most significant bit first
    idx    = {insn[8], insn[12], insn[3], insn[9], insn[6:5], insn[2],
              insn[11:10], insn[4]};
    addr   = (base & ~XLEN'(3)) + {{PadW{1'b0}}, idx, 2'b00};
  end
endmodule

// File: rtl/tblx_jal.sv
module tblx_jal
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]             opc,     // fetched word bits 6:0
  input  logic [19:0]            imm_src, // fetched word bits 31:12
  input  logic [XLEN-REGION_W-1:0] pc_hi,
  output logic                   is_jal,
  output logic [XLEN-1:0]        target
);
  logic [REGION_W-1:0] imm;

  always_comb begin
    is_jal = opc == OPC_JAL;
    // w[31] -> 20, w[19:12] -> 19:12, w[20] -> 11, w[30:21] -> 10:1
    imm    = {imm_src[19], imm_src[7:0], imm_src[8], imm_src[18:9], 1'b0};
    target = {pc_hi, imm};
  end
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_insn,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] tbase,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_insn,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_redirect,
  output logic [XLEN-1:0] out_target,
  output logic            out_illegal,
  output logic            out_fault
);
  tblx_state_e state_q, state_d;

  logic [XLEN-1:0] pc_q, addr_q, tgt_q, tgt_d, addr_d, pc_d;
  logic [31:0]     insn_q, insn_d;
  logic            redir_q, redir_d, ill_q, ill_d, flt_q, flt_d;
  logic            ld_en, addr_en;

  logic            dec_hit, dec_hw;
  logic [XLEN-1:0] dec_addr, jal_tgt;
  logic            jal_hit;

  tblx_decode #(.XLEN(XLEN)) i_decode (
    .insn   (in_insn),
    .base   (tbase),
    .hit    (dec_hit),
    .hw_tab (dec_hw),
    .addr   (dec_addr)
  );

  tblx_jal #(.XLEN(XLEN)) i_jal (
    .opc     (mem_rdata[6:0]),
    .imm_src (mem_rdata[31:12]),
    .pc_hi   (pc_q[XLEN-1:REGION_W]),
    .is_jal  (jal_hit),
    .target  (jal_tgt)
  );

  // next-state and datapath selection
  always_comb begin
    state_d = state_q;
    pc_d    = in_pc;
    addr_d  = dec_addr;
    insn_d  = {16'h0, in_insn};
    redir_d = 1'b0;
    tgt_d   = jal_tgt;
    ill_d   = 1'b0;
    flt_d   = 1'b0;
    ld_en   = 1'b0;
    addr_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          ld_en = 1'b1;
          if (dec_hit && !dec_hw) begin
            addr_en = 1'b1;
            state_d = ST_FETCH;
          end else begin
            ill_d   = dec_hit;
            state_d = ST_OUT;
          end
        end
      end
      ST_FETCH: begin
        pc_d = pc_q;
        if (mem_ack) begin
          ld_en   = 1'b1;
          state_d = ST_OUT;
          if (mem_err) begin
            insn_d = '0;
            flt_d  = 1'b1;
          end else begin
            insn_d  = mem_rdata;
            redir_d = jal_hit;
          end
        end
      end
      ST_OUT: begin
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      pc_q    <= pc_d;
      insn_q  <= insn_d;
      redir_q <= redir_d;
      tgt_q   <= tgt_d;
      ill_q   <= ill_d;
      flt_q   <= flt_d;
    end
    if (addr_en) addr_q <= addr_d;
  end

  always_comb begin
    in_ready     = state_q == ST_IDLE;
    mem_req      = state_q == ST_FETCH;
    mem_addr     = addr_q;
    out_valid    = state_q == ST_OUT;
    out_insn     = insn_q;
    out_next_pc  = pc_q + XLEN'(2);
    out_redirect = redir_q;
    out_target   = tgt_q;
    out_illegal  = ill_q;
    out_fault    = flt_q;
  end
endmodule

// File: rtl/tblx_chk.sv
module tblx_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [15:0]     in_insn,
  input logic [XLEN-1:0] in_pc,
  input logic            tab_flag,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     out_insn,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_redirect,
  input logic [XLEN-1:0] out_target,
  input logic            out_illegal,
  input logic            out_fault
);
  logic take, match;
  assign take  = in_valid && in_ready;
  assign match = (in_insn & 16'hE083) == 16'h8000;

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req && out_valid);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r1_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    take && !match |=> out_valid && !mem_req && !out_illegal);

  a_r3_flag_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    take && match && tab_flag |=> out_valid && out_illegal && !mem_req);

  a_r4_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_next_pc == $past(in_pc) + XLEN'(2));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_insn)
      && $stable(out_redirect) && $stable(out_target) && $stable(out_fault));

  a_r7_fault_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_redirect && !out_illegal);
endmodule

bind tblx_unit tblx_chk #(.XLEN(XLEN)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_insn      (in_insn),
  .in_pc        (in_pc),
  .tab_flag     (tbase[0]),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_insn     (out_insn),
  .out_next_pc  (out_next_pc),
  .out_redirect (out_redirect),
  .out_target   (out_target),
  .out_illegal  (out_illegal),
  .out_fault    (out_fault)
);

// File: tb/test_tblx_unit.sv
module test_tblx_unit;
  logic        clk, rst_n;
  logic        in_valid, in_ready;
  logic [15:0] in_insn;
  logic [31:0] in_pc, tbase;
  logic        mem_req, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        out_valid, out_ready;
  logic [31:0] out_insn, out_next_pc, out_target;
  logic        out_redirect, out_illegal, out_fault;

  int checks = 0;
  int failures = 0;

  tblx_unit #(.XLEN(32)) i_tblx_unit (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_insn (in_insn),
    .in_pc (in_pc), .tbase (tbase),
    .mem_req (mem_req), .mem_addr (mem_addr), .mem_ack (mem_ack),
    .mem_err (mem_err), .mem_rdata (mem_rdata),
    .out_valid (out_valid), .out_ready (out_ready), .out_insn (out_insn),
    .out_next_pc (out_next_pc), .out_redirect (out_redirect),
    .out_target (out_target), .out_illegal (out_illegal), .out_fault (out_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // place index bits at their instruction positions (inverse of the gather)
  function automatic logic [15:0] mk(input logic [9:0] idx);
    logic [15:0] i;
    i = 16'h8000;
    i[8] = idx[9];  i[12] = idx[8]; i[3] = idx[7]; i[9] = idx[6];
    i[6:5] = idx[5:4]; i[2] = idx[3]; i[11:10] = idx[2:1]; i[4] = idx[0];
    return i;
  endfunction

  task automatic run_one(input logic [15:0] insn, input logic [9:0] idx,
                         input logic [31:0] pc, input logic [31:0] base,
                         input logic [31:0] word, input logic err,
                         input int ack_dly, input int rdy_dly);
    logic hit, fetch, jal;
    logic [31:0] e_addr, e_insn, e_tgt;
    bit seen;
    int n;
    hit    = (insn[15:13] == 3'b100) && !insn[7] && (insn[1:0] == 2'b00);
    fetch  = hit && !base[0];
    e_addr = (base & ~32'd3) + {20'd0, idx, 2'b00};
    jal    = fetch && !err && (word[6:0] == 7'b1101111);
    e_tgt  = {pc[31:21], word[31], word[19:12], word[20], word[30:21], 1'b0};
    e_insn = !fetch ? {16'h0, insn} : (err ? 32'h0 : word);
    seen   = 0;
    chk(in_ready === 1'b1, "R8", "in_ready before issue", {31'd0, in_ready}, 1);
    in_valid = 1'b1; in_insn = insn; in_pc = pc; tbase = base;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (out_valid !== 1'b1 && n < 40) begin
      if (mem_req === 1'b1) begin
        seen = 1;
        chk(mem_addr === e_addr, "R2", "table address", mem_addr, e_addr);
        for (int k = 0; k < ack_dly; k++) begin
          @(negedge clk);
          chk(mem_req === 1'b1 && mem_addr === e_addr, "R6", "request held",
              mem_addr, e_addr);
        end
        mem_ack = 1'b1; mem_err = err; mem_rdata = word;
        @(negedge clk);
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(mem_req === 1'b0, "R6", "request dropped after ack", {31'd0, mem_req}, 0);
      end else begin
        @(negedge clk);
      end
      n++;
    end
    chk(seen == fetch, hit ? (base[0] ? "R3" : "R2") : "R1", "fetch issued",
        {31'd0, seen}, {31'd0, fetch});
    chk(out_valid === 1'b1, "R8", "result valid", {31'd0, out_valid}, 1);
    chk(out_insn === e_insn, err ? "R7" : "R4", "out_insn", out_insn, e_insn);
    chk(out_next_pc === pc + 32'd2, "R4", "next pc", out_next_pc, pc + 32'd2);
    chk(out_illegal === (hit && base[0]), "R3", "illegal flag",
        {31'd0, out_illegal}, {31'd0, hit && base[0]});
    chk(out_fault === (fetch && err), "R7", "fault flag",
        {31'd0, out_fault}, {31'd0, fetch && err});
    chk(out_redirect === jal, "R5", "redirect flag",
        {31'd0, out_redirect}, {31'd0, jal});
    if (jal) chk(out_target === e_tgt, "R5", "jal target", out_target, e_tgt);
    for (int k = 0; k < rdy_dly; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_insn === e_insn && in_ready === 1'b0,
          "R8", "held under backpressure", out_insn, e_insn);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R8", "released",
        {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_pc = '0; tbase = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && mem_req === 1'b0, "R9",
        "reset state", {29'd0, in_ready, out_valid, mem_req}, 32'h4);

    // R2 R4 R5 R6 R8: full index sweep
    for (int i = 0; i < 1024; i++) begin
      w = (32'h1234_5600 ^ (i * 32'h0001_0F37));
      w[6:0] = (i % 8 == 0) ? 7'b1101111 : 7'b0010011;
      run_one(mk(10'(i)), 10'(i), 32'hABC0_0000 + i * 32'd6,
              32'h0004_0000 + i * 32'h0010_0000 + ((i % 2) * 2), w, 1'b0,
              i % 3, i % 4);
    end

    // R1: every single-bit miss of the opcode pattern
    foreach (w[b]) begin
      if (b < 16 && ((16'hE083 >> b) & 1)) begin
        run_one(mk(10'h2A5) ^ (16'h1 << b), 10'h2A5, 32'h0000_1000,
                32'h0000_8000, 32'h0, 1'b0, 0, 1);
      end
    end

    // R3: hardware-table flag
    run_one(mk(10'h000), 10'h000, 32'h0010_0002, 32'h0000_9001, 32'h0, 1'b0, 0, 0);
    run_one(mk(10'h3FF), 10'h3FF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0, 1'b0, 0, 2);

    // R7: bus error, including one that carries a JAL-looking word
    run_one(mk(10'h155), 10'h155, 32'h0200_0000, 32'h0001_0000, 32'h0000_006F, 1'b1, 2, 0);
    run_one(mk(10'h0F0), 10'h0F0, 32'h0300_0010, 32'h0002_0000, 32'h1234_5613, 1'b1, 0, 1);

    // R5: JAL with all-ones and alternating immediates, PC near region top
    run_one(mk(10'h001), 10'h001, 32'h7FFF_FFFE, 32'h0000_0000, 32'hFFFF_F0EF, 1'b0, 1, 0);
    run_one(mk(10'h200), 10'h200, 32'h8020_0000, 32'h1000_0000, 32'hAAAA_A06F, 1'b0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule